// File: doc/BRIEF.md
# PUF challenge search controller

This block finds a challenge word for a delay-race physical unclonable function (PUF). The challenge must make the PUF return a wanted target response. The target is normally an encrypted key with its error-correcting syndrome attached, and it is given to the block as a plain input word.

For every candidate the block:
- places the challenge on the switch inputs,
- holds it for a programmable settle time,
- fires a single-cycle excitation pulse,
- samples the response on the following cycle and compares it with the target.

One candidate is tried per evaluation period. The period is a programmable number of clock cycles.

Candidates come from one of two sources. The first is an ascending sweep over every challenge, for small networks. The second is a maximal-length LFSR, for large networks where a full sweep cannot finish. Matches are counted, and the first few are kept in a small buffer. When the search ends, one kept match is chosen at random and offered on a valid/ready storage port, so that the PUF can later be reconfigured from nonvolatile memory.

A search can stop at the first match, after a programmable number of kept matches, or after a trial limit. It can also be aborted.

For `STAGES` stages the challenge is 2^STAGES−1 bits wide and the response is 2^(STAGES−1) bits wide. The configuration inputs must be held stable while `busy` is high.

Top module: `puf_search`

## Requirements
- R1: After reset `busy`, `done`, `st_valid` and `puf_pulse` are low and `match_count` is zero.
- R2: Each new challenge is held on `puf_chal` for exactly max(`settle`,1) cycles before the single-cycle `puf_pulse`. The response is compared on the cycle after the pulse. The first challenge appears on the cycle `busy` rises.
- R3: Exactly one candidate is tried per evaluation period. The period is max(`period`, max(`settle`,1)+2) cycles from one pulse to the next.
- R4: With `rand_mode`=0 the candidates are 0, 1, 2, … in ascending order. The search ends after the all-ones challenge has been tried.
- R5: `match_count` counts the responses equal to `target` in the current search. It saturates at 2^MCNT_W−1 and is cleared on start.
- R6: With `rand_mode`=1 the first candidate is `seed`, or 1 when `seed` is zero. Each next candidate is the Galois right-shift step `(s>>1) ^ (s[0] ? MASK : 0)`. For a 7-bit challenge MASK=7'h60, so no candidate is zero.
- R7: With `rand_mode`=1 and `stop_first`=1 the search ends at the first match, and that challenge is the one stored.
- R8: The first L matches are buffered, where L is `keep_limit` clamped to 1..DEPTH. With `rand_mode`=1 and `stop_first`=0 the search ends once L matches are buffered. The stored challenge is one of the buffered matches.
- R9: A nonzero `max_trials` ends the search after that many candidates. A search that ends with no match raises `done` with `found`=0 and never raises `st_valid`.
- R10: `abort` while `busy` is high and `st_valid` is low ends the search on the next cycle with `done` high, `found`=0 and no storage write.
- R11: `st_valid` holds `st_data` stable until `st_ready`. `done` is a one-cycle pulse in the cycle after acceptance, with `found`=1. `busy` is high from the cycle after `start` until `done`, and low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle |
| abort | input | 1 | End a running search without storing |
| rand_mode | input | 1 | 0 ascending sweep, 1 LFSR candidates |
| stop_first | input | 1 | In LFSR mode, end at the first match |
| keep_limit | input | KEPT_W | Matches to collect (clamped 1..DEPTH) |
| settle | input | PER_W | Settle cycles before the pulse (0 acts as 1) |
| period | input | PER_W | Evaluation period in cycles (minimum settle+2) |
| max_trials | input | TRIAL_W | Trial limit, 0 for none |
| seed | input | CHAL_W | LFSR seed (0 replaced by 1) |
| target | input | RESP_W | Wanted response |
| puf_chal | output | CHAL_W | Challenge to the PUF switches |
| puf_pulse | output | 1 | Excitation pulse |
| puf_resp | input | RESP_W | Arbiter outputs of the PUF |
| st_valid | output | 1 | Chosen challenge offered to storage |
| st_data | output | CHAL_W | Chosen challenge |
| st_ready | input | 1 | Storage accepts the challenge |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Last search stored a challenge |
| match_count | output | MCNT_W | Saturating match count |

## Verification
Driving `match_count` into saturation needs one response value that occurs more often than 2^MCNT_W−1 times over a full sweep. The bench builds a small network with a narrow counter, tallies its stand-in PUF function over every challenge, and sweeps with the most frequent response as target. The random-pick path is hard to pin to one value, so the bench accepts any stored challenge that lies among the first L matches of the sweep and maps to the target. A keep limit of zero, clamped to one, then forces an exact answer. The LFSR order is reached by choosing a target equal to the response of the fourth LFSR state, and seed zero by a target that neither of the first two candidates meets.

// File: rtl/puf_search_pkg.sv
package puf_search_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RUN,
      S_PICK,
      S_WRITE,
      S_FIN
   } srch_state_t;

   // Galois right-shift feedback masks giving maximal length for 2^n-1 wide words
   function automatic logic [63:0] lfsr_mask(input int width);
      case (width)
         3:       return 64'h6;
         7:       return 64'h60;
         15:      return 64'h6000;
         31:      return 64'h4800_0000;
         63:      return 64'h6000_0000_0000_0000;
         default: return 64'h0;
      endcase
   endfunction

endpackage

// File: rtl/puf_search_lfsr.sv
module puf_search_lfsr #(
   parameter int         W    = 31,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);

   logic [W-1:0] seed_eff;
   logic [W-1:0] nxt;

   assign seed_eff = (seed == '0) ? W'(1) : seed;
   assign nxt      = (state >> 1) ^ (state[0] ? MASK : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= W'(1);
      else if (load)
         state <= seed_eff;
      else if (step)
         state <= nxt;
   end

endmodule

// File: rtl/puf_search_timer.sv
module puf_search_timer #(
   parameter int PER_W = 8,
   localparam int PH_W = PER_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [PER_W-1:0] settle,
   input  logic [PER_W-1:0] period,
   output logic             pulse,
   output logic             sample,
   output logic             last
);

   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] settle_eff;
   logic [PH_W-1:0] min_per;
   logic [PH_W-1:0] per_eff;

   assign settle_eff = (settle == '0) ? PH_W'(1) : PH_W'(settle);
   assign min_per    = settle_eff + PH_W'(2);
   assign per_eff    = (PH_W'(period) < min_per) ? min_per : PH_W'(period);

   assign pulse  = run && (phase == settle_eff);
   assign sample = run && (phase == settle_eff + PH_W'(1));
   assign last   = run && (phase == per_eff - PH_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         phase <= '0;
      else if (run)
         phase <= last ? '0 : phase + PH_W'(1);
   end

endmodule

// File: rtl/puf_search_store.sv
module puf_search_store #(
   parameter int W      = 31,
   parameter int DEPTH  = 4,
   parameter int MCNT_W = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int KEPT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [W-1:0]      din,
   input  logic [KEPT_W-1:0] lim,
   input  logic [IDX_W-1:0]  rnd,
   output logic [KEPT_W-1:0] kept_nxt,
   output logic [W-1:0]      pick_data,
   output logic [MCNT_W-1:0] mcount
);

   logic [W-1:0]      slots [DEPTH];
   logic [KEPT_W-1:0] kept;
   logic              take;
   logic [KEPT_W-1:0] sel;

   assign take     = push && (kept < lim);
   assign kept_nxt = kept + KEPT_W'(take);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slots[i] <= '0;
         else if (take && (kept == KEPT_W'(i)))
            slots[i] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         kept   <= '0;
         mcount <= '0;
      end else begin
         kept <= kept_nxt;
         if (push && (mcount != '1))
            mcount <= mcount + MCNT_W'(1);
      end
   end

   // reduce the random index into the number of kept entries
   always_comb begin
      sel = KEPT_W'(rnd);
      if (kept != '0) begin
         for (int k = 0; k < (1 << IDX_W); k++) begin
            if (sel >= kept)
               sel = sel - kept;
         end
      end
      pick_data = slots[sel[IDX_W-1:0]];
   end

endmodule

// File: rtl/puf_search.sv
module puf_search
   import puf_search_pkg::*;
#(
   parameter int STAGES  = 5,
   parameter int DEPTH   = 4,
   parameter int MCNT_W  = 8,
   parameter int TRIAL_W = 32,
   parameter int PER_W   = 8,
   localparam int CHAL_W = (1 << STAGES) - 1,
   localparam int RESP_W = 1 << (STAGES - 1),
   localparam int KEPT_W = $clog2(DEPTH + 1),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               abort,
   input  logic               rand_mode,
   input  logic               stop_first,
   input  logic [KEPT_W-1:0]  keep_limit,
   input  logic [PER_W-1:0]   settle,
   input  logic [PER_W-1:0]   period,
   input  logic [TRIAL_W-1:0] max_trials,
   input  logic [CHAL_W-1:0]  seed,
   input  logic [RESP_W-1:0]  target,
   output logic [CHAL_W-1:0]  puf_chal,
   output logic               puf_pulse,
   input  logic [RESP_W-1:0]  puf_resp,
   output logic               st_valid,
   output logic [CHAL_W-1:0]  st_data,
   input  logic               st_ready,
   output logic               busy,
   output logic               done,
   output logic               found,
   output logic [MCNT_W-1:0]  match_count
);

   localparam logic [63:0] MASK64 = lfsr_mask(CHAL_W);

   if (STAGES < 2 || STAGES > 6) begin : g_bad_stages
      $error("puf_search: STAGES must lie in 2..6");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("puf_search: DEPTH must be at least 2");
   end
   if (MASK64 == 64'h0) begin : g_bad_mask
      $error("puf_search: no feedback mask for this challenge width");
   end

   srch_state_t        state;
   logic [CHAL_W-1:0]  sweep_q;
   logic [TRIAL_W-1:0] trials_q;
   logic [CHAL_W-1:0]  lfsr_q;
   logic [CHAL_W-1:0]  pick_q;
   logic [CHAL_W-1:0]  pick_data;
   logic [KEPT_W-1:0]  lim_eff;
   logic [KEPT_W-1:0]  kept_nxt;
   logic               t_pulse, t_sample, t_last;
   logic               launch, running, hit, stop_hit, end_sweep, trial_cap;

   assign launch  = (state == S_IDLE) && start;
   assign running = (state == S_RUN);
   assign lim_eff = (keep_limit == '0)             ? KEPT_W'(1) :
                    (keep_limit > KEPT_W'(DEPTH)) ? KEPT_W'(DEPTH) : keep_limit;

   puf_search_lfsr #(
      .W    (CHAL_W),
      .MASK (MASK64[CHAL_W-1:0])
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (launch),
      .step  (running && t_last),
      .seed  (seed),
      .state (lfsr_q)
   );

   puf_search_timer #(
      .PER_W (PER_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (launch),
      .run     (running),
      .settle  (settle),
      .period  (period),
      .pulse   (t_pulse),
      .sample  (t_sample),
      .last    (t_last)
   );

   assign puf_chal = rand_mode ? lfsr_q : sweep_q;
   assign hit      = t_sample && (puf_resp == target);

   puf_search_store #(
      .W      (CHAL_W),
      .DEPTH  (DEPTH),
      .MCNT_W (MCNT_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .push      (hit && !abort),
      .din       (puf_chal),
      .lim       (lim_eff),
      .rnd       (lfsr_q[IDX_W-1:0]),
      .kept_nxt  (kept_nxt),
      .pick_data (pick_data),
      .mcount    (match_count)
   );

   assign trial_cap = (max_trials != '0) && (trials_q + TRIAL_W'(1) == max_trials);
   assign stop_hit  = hit && rand_mode && (stop_first || (kept_nxt >= lim_eff));
   assign end_sweep = t_last && (trial_cap || (!rand_mode && (sweep_q == '1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         sweep_q  <= '0;
         trials_q <= '0;
         pick_q   <= '0;
         found    <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  state    <= S_RUN;
                  sweep_q  <= '0;
                  trials_q <= '0;
                  found    <= 1'b0;
               end
            end
            S_RUN: begin
               if (abort)
                  state <= S_FIN;
               else if (stop_hit)
                  state <= S_PICK;
               else if (end_sweep)
                  state <= (kept_nxt != '0) ? S_PICK : S_FIN;
               else if (t_last) begin
                  sweep_q  <= sweep_q + CHAL_W'(1);
                  trials_q <= trials_q + TRIAL_W'(1);
               end
            end
            S_PICK: begin
               if (abort)
                  state <= S_FIN;
               else begin
                  pick_q <= pick_data;
                  state  <= S_WRITE;
               end
            end
            S_WRITE: begin
               if (st_ready) begin
                  found <= 1'b1;
                  state <= S_FIN;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign puf_pulse = t_pulse;
   assign st_valid  = (state == S_WRITE);
   assign st_data   = pick_q;
   assign busy      = (state != S_IDLE) && (state != S_FIN);
   assign done      = (state == S_FIN);

endmodule

// File: rtl/puf_search_checker.sv
module puf_search_checker #(
   parameter int CHAL_W = 31,
   parameter int PER_W  = 8,
   parameter int MCNT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CHAL_W-1:0] puf_chal,
   input logic              puf_pulse,
   input logic [PER_W-1:0]  settle,
   input logic              rand_mode,
   input logic              abort,
   input logic              st_valid,
   input logic              st_ready,
   input logic [CHAL_W-1:0] st_data,
   input logic              busy,
   input logic              done,
   input logic              found,
   input logic [MCNT_W-1:0] match_count
);

   logic [CHAL_W-1:0] chal_prev;
   logic [PER_W:0]    run_len;
   logic [PER_W:0]    cur_len;
   logic [PER_W:0]    settle_need;

   assign cur_len     = (puf_chal != chal_prev) ? '0 :
                        (run_len == '1) ? run_len : run_len + 1'b1;
   assign settle_need = (settle == '0) ? (PER_W+1)'(1) : (PER_W+1)'(settle);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chal_prev <= '0;
         run_len   <= '0;
      end else begin
         chal_prev <= puf_chal;
         run_len   <= cur_len;
      end
   end

   // R2: the challenge has been stable for the settle interval when the pulse fires
   assert_settle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      puf_pulse |-> (cur_len >= settle_need));

   // R2: the pulse lasts one cycle
   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      puf_pulse |=> !puf_pulse);

   // R6: LFSR candidates are never zero
   assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (puf_pulse && rand_mode) |-> (puf_chal != '0));

   // R5: a saturated count stays saturated within a search
   assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && ($past(match_count) == '1)) |-> (match_count == '1));

   // R10: abort before the storage offer ends the search unfound
   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort && !st_valid) |=> (done && !found));

   // R11: storage offer is held until taken
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

   // R11: a successful done follows an accepted write
   assert_done_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> $past(st_valid && st_ready));

   // R11: busy is low while done is high
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind puf_search puf_search_checker #(
   .CHAL_W (CHAL_W),
   .PER_W  (PER_W),
   .MCNT_W (MCNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .puf_chal    (puf_chal),
   .puf_pulse   (puf_pulse),
   .settle      (settle),
   .rand_mode   (rand_mode),
   .abort       (abort),
   .st_valid    (st_valid),
   .st_ready    (st_ready),
   .st_data     (st_data),
   .busy        (busy),
   .done        (done),
   .found       (found),
   .match_count (match_count)
);

// File: tb/puf_search_test.sv
module puf_search_test;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 7;
   localparam int RW = 4;
   localparam int SAT = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, abort = 1'b0, rand_mode = 1'b0, stop_first = 1'b0;
   logic [2:0]    keep_limit = '0;
   logic [7:0]    settle = 8'd1, period = 8'd4;
   logic [15:0]   max_trials = '0;
   logic [CW-1:0] seed = '0;
   logic [RW-1:0] target = '0;
   logic [CW-1:0] puf_chal;
   logic          puf_pulse;
   logic [RW-1:0] puf_resp;
   logic          st_valid;
   logic [CW-1:0] st_data;
   logic          st_ready = 1'b0;
   logic          busy, done, found;
   logic [2:0]    match_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [RW-1:0] pufm(input logic [CW-1:0] c);
      logic [7:0] t;
      t = ({1'b0, c} * 8'd3) ^ {5'b0, c[6:4]};
      return t[3:0] ^ t[7:4];
   endfunction

   function automatic logic [CW-1:0] lfsr_step(input logic [CW-1:0] s);
      return (s >> 1) ^ (s[0] ? 7'h60 : 7'h00);
   endfunction

   assign puf_resp = pufm(puf_chal);

   puf_search #(
      .STAGES (3), .DEPTH (4), .MCNT_W (3), .TRIAL_W (16), .PER_W (8)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .abort (abort),
      .rand_mode (rand_mode), .stop_first (stop_first), .keep_limit (keep_limit),
      .settle (settle), .period (period), .max_trials (max_trials), .seed (seed),
      .target (target), .puf_chal (puf_chal), .puf_pulse (puf_pulse),
      .puf_resp (puf_resp), .st_valid (st_valid), .st_data (st_data),
      .st_ready (st_ready), .busy (busy), .done (done), .found (found),
      .match_count (match_count)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct {
      int cnt;
      bit chk_cnt;
      bit fnd;
      bit exact;
      int want;
      int maxc;
      int tgt;
   } exp_t;

   exp_t          sbq[$];
   logic [CW-1:0] plog[$];
   int            exp_settle = 1, exp_period = 3;

   // monitor state
   int            settle_len = 0, gap = 0, vwait = 0;
   bit            have_pulse = 0, prev_busy = 0, acc_pend = 0, acc_seen = 0, valid_seen = 0;
   logic [CW-1:0] prev_chal = '0, held = '0, acc_data = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !prev_busy) begin
            settle_len = 0; gap = 0; have_pulse = 0; valid_seen = 0; acc_seen = 0;
         end else if (puf_chal == prev_chal)
            settle_len++;
         else
            settle_len = 0;
         gap++;
         if (puf_pulse) begin
            plog.push_back(puf_chal);
            chk(settle_len == exp_settle, "R2 settle", settle_len, exp_settle);
            if (have_pulse) chk(gap == exp_period, "R3 period", gap, exp_period);
            have_pulse = 1;
            gap = 0;
         end
         prev_chal = puf_chal;
         prev_busy = busy;

         if (acc_pend) begin
            chk(done == 1'b1, "R11 done after accept", int'(done), 1);
            acc_pend = 0;
         end
         if (st_valid) begin
            valid_seen = 1;
            if (vwait > 0) chk(st_data == held, "R11 hold", int'(st_data), int'(held));
            held = st_data;
            vwait++;
            st_ready = (vwait >= 3);
            if (st_ready) begin
               acc_pend = 1; acc_seen = 1; acc_data = st_data;
            end
         end else begin
            vwait = 0;
            st_ready = 1'b0;
         end

         if (done) begin
            chk(!busy, "R11 busy low at done", int'(busy), 0);
            if (sbq.size() == 0)
               chk(1'b0, "R11 unexpected done", 1, 0);
            else begin
               exp_t e;
               e = sbq.pop_front();
               chk(found == e.fnd, "R9 found", int'(found), int'(e.fnd));
               if (e.chk_cnt) chk(match_count == e.cnt, "R5 count", int'(match_count), e.cnt);
               if (e.fnd) begin
                  chk(acc_seen, "R11 write seen", int'(acc_seen), 1);
                  if (e.exact)
                     chk(acc_data == e.want, "R7 stored", int'(acc_data), e.want);
                  else
                     chk((pufm(acc_data) == e.tgt) && (acc_data <= e.maxc),
                         "R8 stored", int'(acc_data), e.maxc);
               end else
                  chk(!valid_seen, "R9 no write", int'(valid_seen), 0);
            end
         end
      end
   end

   task automatic run(input bit rm, input bit sf, input int lim, input int st, input int per,
                      input int mt, input int sd, input int tg, input exp_t e, input int abort_at);
      @(negedge clk);
      rand_mode = rm; stop_first = sf; keep_limit = 3'(lim); settle = 8'(st); period = 8'(per);
      max_trials = 16'(mt); seed = CW'(sd); target = RW'(tg);
      exp_settle = (st == 0) ? 1 : st;
      exp_period = (per < exp_settle + 2) ? exp_settle + 2 : per;
      plog.delete();
      sbq.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
      if (abort_at > 0) begin
         repeat (abort_at) @(negedge clk);
         abort = 1'b1;
         @(negedge clk);
         abort = 1'b0;
      end
      while (sbq.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   function automatic void exh_model(input int tg, input int mt, input int lim,
                                     output int cnt, output int maxc);
      cnt = 0; maxc = 0;
      for (int c = 0; c < 128; c++) begin
         if (mt != 0 && c >= mt) break;
         if (pufm(CW'(c)) == tg) begin
            cnt++;
            if (cnt <= lim) maxc = c;
         end
      end
   endfunction

   function automatic void rnd_model(input int sd, input int tg, input int mt, input bit sf,
                                     input int lim, output int cnt, output int want,
                                     output int npulse);
      logic [CW-1:0] s;
      int n;
      s = (sd == 0) ? CW'(1) : CW'(sd);
      n = 0; cnt = 0; want = 0;
      while (n < 300 && (mt == 0 || n < mt)) begin
         n++;
         if (pufm(s) == tg) begin
            cnt++;
            want = s;
            if (sf || cnt >= lim) break;
         end
         s = lfsr_step(s);
      end
      npulse = n;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      exp_t e;
      int   cnt, maxc, want, np, tmax, t1, tg, misord;
      int   tcnt[16];
      logic [CW-1:0] s[4];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !st_valid && !puf_pulse, "R1 idle outputs",
          int'({busy, done, st_valid, puf_pulse}), 0);
      chk(match_count == 0, "R1 count", int'(match_count), 0);

      foreach (tcnt[i]) tcnt[i] = 0;
      for (int c = 0; c < 128; c++) tcnt[pufm(CW'(c))]++;
      tmax = 0;
      for (int i = 1; i < 16; i++) if (tcnt[i] > tcnt[tmax]) tmax = i;
      t1 = pufm(CW'(5));

      // full sweep, R4 R5 R8
      exh_model(t1, 0, 4, cnt, maxc);
      e = '{cnt: (cnt > SAT) ? SAT : cnt, chk_cnt: 1, fnd: cnt > 0, exact: 0, want: 0,
            maxc: maxc, tgt: t1};
      run(0, 0, 4, 1, 4, 0, 0, t1, e, 0);
      chk(plog.size() == 128, "R4 trials", plog.size(), 128);
      misord = 0;
      foreach (plog[i]) if (plog[i] != CW'(i)) misord++;
      chk(misord == 0, "R4 order", misord, 0);

      // saturation and keep limit 0 clamped to 1, settle 0 acts as 1, R5 R8 R2
      exh_model(tmax, 0, 1, cnt, maxc);
      e = '{cnt: (cnt > SAT) ? SAT : cnt, chk_cnt: 1, fnd: 1, exact: 1, want: maxc,
            maxc: maxc, tgt: tmax};
      run(0, 0, 0, 0, 3, 0, 0, tmax, e, 0);
      chk(cnt > SAT, "R5 saturation reached", cnt, SAT + 1);

      // period below settle+2 stretched, trial limit, R3 R9
      exh_model(t1, 10, 4, cnt, maxc);
      e = '{cnt: cnt, chk_cnt: 1, fnd: cnt > 0, exact: 0, want: 0, maxc: maxc, tgt: t1};
      run(0, 0, 4, 3, 2, 10, 0, t1, e, 0);
      chk(plog.size() == 10, "R9 trial limit", plog.size(), 10);

      // no match within one trial, R9
      tg = pufm(CW'(0)) ^ 4'h1;
      e = '{cnt: 0, chk_cnt: 1, fnd: 0, exact: 0, want: 0, maxc: 0, tgt: tg};
      run(0, 0, 4, 1, 4, 1, 0, tg, e, 0);

      // LFSR order and stop at first match, R6 R7
      s[0] = 7'h2A;
      for (int i = 1; i < 4; i++) s[i] = lfsr_step(s[i-1]);
      tg = pufm(s[3]);
      rnd_model(32'h2A, tg, 0, 1, 4, cnt, want, np);
      e = '{cnt: cnt, chk_cnt: 1, fnd: 1, exact: 1, want: want, maxc: 0, tgt: tg};
      run(1, 1, 4, 1, 4, 0, 32'h2A, tg, e, 0);
      chk(plog.size() == np, "R7 trials", plog.size(), np);
      for (int i = 0; i < 3 && i < np; i++)
         chk(plog[i] == s[i], "R6 sequence", int'(plog[i]), int'(s[i]));

      // seed zero replaced by 1, R6
      tg = 0;
      while (tg == pufm(CW'(1)) || tg == pufm(CW'(7'h60))) tg++;
      e = '{cnt: 0, chk_cnt: 1, fnd: 0, exact: 0, want: 0, maxc: 0, tgt: tg};
      run(1, 1, 4, 2, 5, 2, 0, tg, e, 0);
      chk(plog.size() == 2, "R6 seed zero trials", plog.size(), 2);
      if (plog.size() == 2) begin
         chk(plog[0] == 7'h01, "R6 seed zero first", int'(plog[0]), 1);
         chk(plog[1] == 7'h60, "R6 seed zero second", int'(plog[1]), 32'h60);
      end

      // LFSR collection of three matches, R8
      rnd_model(32'h11, t1, 0, 0, 3, cnt, want, np);
      e = '{cnt: cnt, chk_cnt: 1, fnd: cnt > 0, exact: 0, want: 0, maxc: 127, tgt: t1};
      run(1, 0, 3, 1, 4, 0, 32'h11, t1, e, 0);
      chk(plog.size() == np, "R8 collect trials", plog.size(), np);

      // abort mid-sweep, R10
      e = '{cnt: 0, chk_cnt: 0, fnd: 0, exact: 0, want: 0, maxc: 0, tgt: t1};
      run(0, 0, 4, 2, 6, 0, 0, t1, e, 14);
      chk(!busy, "R10 idle after abort", int'(busy), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule